// File: doc/BRIEF.md
# Microprogram Sequencer with Branch Modification

This block is the control unit of a microprogrammed processor. It keeps an on-chip store of 64 microinstructions and issues one control word per clock cycle to a datapath that lies outside the block. Each microinstruction has four parts: a control field, a two-bit condition selector, a branch target and an End bit. A fifth bit says whether the target may be changed by the addressing-mode input. The address of the next word is chosen from four sources. The default is the current address plus one. A new instruction in the instruction register selects a start address derived from its opcode. A microbranch whose condition holds selects its target. An End word selects the first word of the fetch routine.

The next word is read while the current one is on the outputs. When the flow leaves the straight line, the word already read is thrown away and the store is read again at the new address. This costs one bubble cycle. A two-state machine tracks this. In FILL the outputs carry no valid word. In RUN a word is being executed. Reset enters FILL. The transition FILL→RUN happens after one refill cycle. The transition RUN→FILL (redirect) happens on an instruction load, on an End word, or on a taken microbranch. FILL→FILL happens when an instruction load arrives during a bubble. RUN→RUN happens on plain increments.

The microcode layout is generated from the address. Words 0 to 3 form the fetch routine. Each opcode k owns four words starting at 16+4k. Branch targets lie in the region from 48 to 63.

Top module: `microseq`

## Requirements
- R1: While rst_n is low, uc_valid is 0 and ctrl is 0. At the first rising edge after release, word 0 appears with uc_valid high.
- R2: While in RUN with no redirect, the next cycle shows upc+1 with uc_valid high. Straight-line code never stalls.
- R3: When uc_valid is high, ctrl equals the low 8 bits of (upc XOR 0xA5). During a bubble, ctrl is all zero.
- R4: When ir_load is high at a rising edge, the sample after that edge is a bubble. The sample one edge later shows upc = 16 + 4*opcode.
- R5: The second word of every routine (address 16+4k+1) is a microbranch. Its selector equals k mod 4, with this encoding: 0 never taken, 1 always taken, 2 taken when cond_in[0] is 1, 3 taken when cond_in[1] is 1. A taken branch gives one bubble and then target 48+4*(k mod 4). A branch that is not taken continues at the next address.
- R6: For opcodes 0 to 3, the branch target has its LSB ORed with mode_in. For opcodes 4 to 7, mode_in has no effect on the target.
- R7: Words at address 16 or above whose low two address bits are 3 carry End. After an End word comes one bubble and then word 0.
- R8: Word 3, the last word of the fetch routine, is an unconditional branch to itself. Without ir_load, the outputs alternate between word 3 and a bubble.
- R9: ir_load takes priority over an End or a taken branch in the word currently shown. The start address of the new opcode follows after one bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_load | input | 1 | A new instruction has been loaded this cycle |
| opcode | input | 3 | Opcode of the instruction being loaded |
| mode_in | input | 1 | Addressing-mode bit used for target modification |
| cond_in | input | 2 | Condition flags tested by microbranches |
| uc_valid | output | 1 | A valid microinstruction is on the outputs |
| upc | output | 6 | Address of the microinstruction shown |
| ctrl | output | 8 | Control field of the shown word, zero during a bubble |

## Verification
Straight-line words show up one per rising edge. An instruction load, an End word or a taken branch puts a bubble on the very next sample and the new address on the sample after that. The branch and End decisions are taken from the word shown in the cycle before the bubble. The bench queues one expected entry per rising edge, either a bubble or an address, in exactly that order. A monitor pops one entry 2 ns after each edge, and the driver changes inputs only on falling edges, so every expectation lines up with the edge that produces it.

// File: rtl/microseq_pkg.sv
package microseq_pkg;
    localparam int COND_W = 2;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_NEVER  = 2'd0,
        SEL_ALWAYS = 2'd1,
        SEL_FLAG0  = 2'd2,
        SEL_FLAG1  = 2'd3
    } cond_sel_e;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/microseq_store.sv
module microseq_store
    import microseq_pkg::*;
#(
    parameter int AW     = 6,
    parameter int CTRL_W = 8,
    parameter int WORD_W = CTRL_W + SEL_W + AW + 2
) (
    input  logic              clk,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH      = 1 << AW;
    localparam int QUART      = 1 << (AW - 2);
    localparam int BASE       = QUART;
    localparam int TGT_BASE   = 3 * QUART;
    localparam int STRIDE     = 4;
    localparam int FETCH_LAST = 3;
    localparam int HALF_OPS   = (1 << (AW - 3)) / 2;

    // Build one word of microcode from its address.
    function automatic logic [WORD_W-1:0] make_word(input int a);
        logic [CTRL_W-1:0] c;
        logic [SEL_W-1:0]  s;
        logic [AW-1:0]     t;
        logic              m;
        logic              e;
        int                op;
        c = CTRL_W'(a) ^ CTRL_W'('hA5);
        s = '0;
        t = '0;
        m = 1'b0;
        e = 1'b0;
        if (a == FETCH_LAST) begin
            s = SEL_ALWAYS;
            t = AW'(FETCH_LAST);
        end else if (a >= BASE) begin
            e = ((a % STRIDE) == STRIDE - 1);
            if (a < TGT_BASE && (a % STRIDE) == 1) begin
                op = (a - BASE) / STRIDE;
                s  = SEL_W'(op % 4);
                t  = AW'(TGT_BASE + STRIDE * (op % 4));
                m  = (op < HALF_OPS);
            end
        end
        return {e, m, t, s, c};
    endfunction

    logic [WORD_W-1:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = make_word(i);
    end

    always_ff @(posedge clk) begin
        rdata <= rom[raddr];
    end
endmodule

// File: rtl/microseq_branch.sv
module microseq_branch
    import microseq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [COND_W-1:0] cond_in,
    input  logic [AW-1:0]     target,
    input  logic              modify,
    input  logic              mode_in,
    output logic              taken,
    output logic [AW-1:0]     dest
);
    always_comb begin
        unique case (cond_sel_e'(sel))
            SEL_NEVER:  taken = 1'b0;
            SEL_ALWAYS: taken = 1'b1;
            SEL_FLAG0:  taken = cond_in[0];
            SEL_FLAG1:  taken = cond_in[1];
            default:    taken = 1'b0;
        endcase
        dest = target | {{(AW-1){1'b0}}, modify & mode_in};
    end

    always_comb begin
        if (!modify) assert_nomod_R6: assert (dest == target);
    end
endmodule

// File: rtl/microseq_next.sv
module microseq_next #(
    parameter int AW   = 6,
    parameter int OP_W = AW - 3
) (
    input  logic [AW-1:0]   fa_q,
    input  logic            ir_load,
    input  logic [OP_W-1:0] opcode,
    input  logic            end_hit,
    input  logic            br_hit,
    input  logic [AW-1:0]   br_dest,
    output logic [AW-1:0]   start_addr,
    output logic [AW-1:0]   fa_d
);
    localparam int BASE   = 1 << (AW - 2);
    localparam int STEP_W = 2;
    localparam logic [AW-1:0] FETCH_START = '0;

    always_comb begin
        start_addr = AW'(BASE) + AW'({opcode, {STEP_W{1'b0}}});
        if (ir_load)      fa_d = start_addr;
        else if (end_hit) fa_d = FETCH_START;
        else if (br_hit)  fa_d = br_dest;
        else              fa_d = fa_q + 1'b1;
    end
endmodule

// File: rtl/microseq.sv
module microseq
    import microseq_pkg::*;
#(
    parameter int AW     = 6,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_load,
    input  logic [AW-4:0]     opcode,
    input  logic              mode_in,
    input  logic [COND_W-1:0] cond_in,
    output logic              uc_valid,
    output logic [AW-1:0]     upc,
    output logic [CTRL_W-1:0] ctrl
);
    localparam int OP_W    = AW - 3;
    localparam int WORD_W  = CTRL_W + SEL_W + AW + 2;
    localparam int SEL_LO  = CTRL_W;
    localparam int TGT_LO  = CTRL_W + SEL_W;
    localparam int MOD_BIT = CTRL_W + SEL_W + AW;
    localparam int END_BIT = WORD_W - 1;

    seq_state_e        state_q, state_d;
    logic [AW-1:0]     fa_q, fa_d, cur_addr_q, start_addr, br_dest;
    logic [WORD_W-1:0] cur_word;
    logic              taken, end_hit, br_hit, redirect;

    microseq_store #(.AW(AW), .CTRL_W(CTRL_W), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .raddr (fa_q),
        .rdata (cur_word)
    );

    microseq_branch #(.AW(AW)) u_branch (
        .sel     (cur_word[SEL_LO +: SEL_W]),
        .cond_in (cond_in),
        .target  (cur_word[TGT_LO +: AW]),
        .modify  (cur_word[MOD_BIT]),
        .mode_in (mode_in),
        .taken   (taken),
        .dest    (br_dest)
    );

    microseq_next #(.AW(AW), .OP_W(OP_W)) u_next (
        .fa_q       (fa_q),
        .ir_load    (ir_load),
        .opcode     (opcode),
        .end_hit    (end_hit),
        .br_hit     (br_hit),
        .br_dest    (br_dest),
        .start_addr (start_addr),
        .fa_d       (fa_d)
    );

    // State register and fetch address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_FILL;
            fa_q       <= '0;
            cur_addr_q <= '0;
        end else begin
            state_q    <= state_d;
            fa_q       <= fa_d;
            cur_addr_q <= fa_q;
        end
    end

    // Transitions and outputs
    always_comb begin
        end_hit  = 1'b0;
        br_hit   = 1'b0;
        uc_valid = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                uc_valid = 1'b1;
                end_hit  = cur_word[END_BIT];
                br_hit   = taken;
            end
            ST_FILL: begin
                uc_valid = 1'b0;
            end
            default: uc_valid = 1'b0;
        endcase
        redirect = ir_load | end_hit | br_hit;
        state_d  = redirect ? ST_FILL : ST_RUN;
        upc      = cur_addr_q;
        ctrl     = uc_valid ? cur_word[CTRL_W-1:0] : '0;
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !redirect) |=> (uc_valid && upc == $past(upc) + 1'b1));

    assert_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> !uc_valid);

    assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> (fa_q == $past(start_addr)));

    assert_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_hit && !end_hit && !ir_load) |=> (fa_q == $past(br_dest) && !uc_valid));

    assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_hit && !ir_load) |=> (fa_q == '0 && !uc_valid));
endmodule

// File: tb/test_microseq.sv
module test_microseq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_load = 1'b0;
    logic [2:0] opcode = '0;
    logic       mode_in = 1'b0;
    logic [1:0] cond_in = '0;
    logic       uc_valid;
    logic [5:0] upc;
    logic [7:0] ctrl;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    microseq i_microseq (
        .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .opcode(opcode),
        .mode_in(mode_in), .cond_in(cond_in),
        .uc_valid(uc_valid), .upc(upc), .ctrl(ctrl)
    );

    // -1 marks a bubble
    task automatic push(input int e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic push_fetch_tail();
        push(-1, "R7 end bubble");
        for (int a = 0; a < 4; a++) push(a, "R8 fetch");
        push(-1, "R8 spin bubble");
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // Expected routine per R4..R7
    task automatic run_op(input int op, input bit md, input bit [1:0] fl);
        int  s, sel, t;
        bit  tk;
        ir_load = 1'b1; opcode = 3'(op); mode_in = md; cond_in = fl;
        s   = 16 + 4 * op;
        sel = op % 4;
        tk  = (sel == 1) || (sel == 2 && fl[0]) || (sel == 3 && fl[1]);
        push(-1, "R4 load bubble");
        push(s, "R4 start");
        push(s + 1, "R2 step");
        if (tk) begin
            push(-1, "R5 taken bubble");
            t = 48 + 4 * sel;
            if (op < 4 && md) t = t | 1;
            for (int a = t; a <= ((t & ~3) + 3); a++) push(a, (op < 4) ? "R6 target" : "R5 target");
        end else begin
            push(s + 2, "R5 not taken");
            push(s + 3, "R2 step");
        end
        push_fetch_tail();
        @(negedge clk);
        ir_load = 1'b0;
        drain();
    endtask

    // Monitor: one expectation per rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (e < 0) begin
                    if (uc_valid !== 1'b0 || ctrl !== 8'h00) begin
                        n_bad++;
                        $display("FAIL %s (R3): valid=%b ctrl=%h expected bubble valid=0 ctrl=00",
                                 t, uc_valid, ctrl);
                    end
                end else if (uc_valid !== 1'b1 || upc !== 6'(e) || ctrl !== (8'(e) ^ 8'hA5)) begin
                    n_bad++;
                    $display("FAIL %s (R3): valid=%b upc=%0d ctrl=%h expected valid=1 upc=%0d ctrl=%h",
                             t, uc_valid, upc, ctrl, e, 8'(e) ^ 8'hA5);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;
        if (uc_valid !== 1'b0 || ctrl !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 reset: valid=%b ctrl=%h expected 0/00", uc_valid, ctrl);
        end
        rst_n = 1'b1;
        push(0, "R1 first word");
        push(1, "R2 step");
        push(2, "R2 step");
        push(3, "R8 spin word");
        push(-1, "R8 spin bubble");
        push(3, "R8 spin word");
        push(-1, "R8 spin bubble");
        drain();

        run_op(0, 1'b1, 2'b11);  // never taken
        run_op(1, 1'b1, 2'b00);  // always, LSB set
        run_op(1, 1'b0, 2'b00);  // always, no mode
        run_op(2, 1'b1, 2'b01);  // flag0 taken, modified
        run_op(2, 1'b1, 2'b10);  // flag0 clear
        run_op(3, 1'b0, 2'b10);  // flag1 taken
        run_op(5, 1'b1, 2'b00);  // R6 mode ignored
        run_op(6, 1'b0, 2'b01);
        run_op(7, 1'b1, 2'b01);  // flag1 clear

        // R9: load overrides a taken branch
        ir_load = 1'b1; opcode = 3'd1; mode_in = 1'b0; cond_in = 2'b00;
        push(-1, "R4 load bubble"); push(20, "R4 start"); push(21, "R9 branch word");
        @(negedge clk); ir_load = 1'b0;
        drain();
        ir_load = 1'b1; opcode = 3'd0;
        push(-1, "R9 override bubble");
        for (int a = 16; a < 20; a++) push(a, "R9 new routine");
        @(negedge clk); ir_load = 1'b0;
        drain();
        // R9: load overrides an End word (19 now shown)
        ir_load = 1'b1; opcode = 3'd7; cond_in = 2'b00;
        push(-1, "R9 override bubble");
        for (int a = 44; a < 48; a++) push(a, "R9 new routine");
        push_fetch_tail();
        @(negedge clk); ir_load = 1'b0;
        drain();

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule